// File: doc/BRIEF.md
# Receive Data Link Message FIFO

This block is the byte buffer between the receive side of a bit-oriented (HDLC-style) data link controller and a CPU register interface. The receiver pushes message bytes one at a time and marks the end of each message with a completion code. The block stores every message segment behind a descriptor byte that gives the segment's byte count and how it ended. The CPU then pulls descriptor and data bytes through a single read port, and a flag tells it which kind of byte comes next.

The writer runs three states. `W_IDLE` has no segment open. `W_OPEN` has reserved a descriptor slot and is collecting bytes. `W_DROP` discards the rest of a message after an overflow. The transitions are:
- `W_IDLE -> W_OPEN`: the first byte of a segment arrives, there is room for it, and the segment is not closed in the same cycle.
- `W_OPEN -> W_IDLE`: the segment closes, either because the message ends or because the block forces a continuation.
- `W_IDLE -> W_DROP`: a byte arrives without room for a new segment.
- `W_DROP -> W_IDLE`: the end-of-message marker arrives.

The reader runs two states. `R_STAT` means the next byte is a descriptor. `R_DATA` means bytes counted by the last descriptor remain. The transitions are:
- `R_STAT -> R_DATA`: a descriptor with a non-zero count is popped.
- `R_DATA -> R_STAT`: the last counted byte is popped.

A programmable threshold drives a near-full level and a latched interrupt. A sticky bit records overflow.

Top module: `dlrx_msg_fifo`

## Requirements
- R1: The buffer holds 64 slots, and descriptor and data bytes both use slots. The fill level counts every written slot not yet read, including the descriptor slot reserved by an open segment. The fill level never exceeds 64.
- R2: A descriptor byte precedes the data of each segment. Bits [7:6] hold the completion code: 00 continued, 01 good FCS, 10 bad FCS, 11 abort. Bits [5:0] hold the number of data bytes that follow.
- R3: A segment becomes readable only in the cycle after it closes. While only an open segment is stored, `cpu_rd_avail` stays low.
- R4: A segment is closed with code 00 when the byte just written leaves no free slot, or when its count reaches 63. The rest of the message goes into a later segment. An end marker in `W_IDLE` with no byte writes a descriptor with count 0.
- R5: `cpu_next_is_stat` is high after reset and after the last counted data byte is read. It drops after a descriptor with a non-zero count is read, and stays high after a count-0 descriptor is read.
- R6: A read while `cpu_rd_avail` is low returns 0 and leaves the read position unchanged.
- R7: `near_full` is high exactly while the fill level is greater than `nf_thresh` (0 to 63).
- R8: `near_full_irq` sets in the cycle after `near_full` rises. It holds until `irq_clr` is pulsed. A new set wins over a clear in the same cycle.
- R9: A byte that arrives in `W_IDLE` with fewer than two free slots sets `overflow`. If exactly one slot is free, that slot receives a descriptor 0xC0 (abort, count 0). The remaining bytes of that message are discarded up to its end marker. `overflow` holds until `ovf_clr` is pulsed.
- R10: After reset the buffer is empty, `cpu_rd_avail`, `near_full`, `near_full_irq` and `overflow` are low, and `cpu_rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte_vld | input | 1 | A received message byte is present |
| rx_byte | input | 8 | Received message byte |
| rx_end_vld | input | 1 | The current message ends this cycle, after the byte if one is present |
| rx_end_code | input | 2 | Completion code for the ending message (01, 10 or 11) |
| nf_thresh | input | 6 | Near-full threshold |
| cpu_rd | input | 1 | CPU read strobe; pops one byte when data is available |
| cpu_rd_data | output | 8 | Byte at the read position, 0 when nothing is readable |
| cpu_rd_avail | output | 1 | At least one committed byte is readable |
| cpu_next_is_stat | output | 1 | The next byte read is a descriptor |
| near_full | output | 1 | Fill level above threshold |
| near_full_irq | output | 1 | Latched near-full interrupt |
| irq_clr | input | 1 | Clears `near_full_irq` |
| overflow | output | 1 | Sticky overflow indication |
| ovf_clr | input | 1 | Clears `overflow` |

## Verification
The assertions take for granted that `rx_end_code` is never 00 on an end marker. They also take for granted that `rx_end_vld` in `W_OPEN` always belongs to the message being collected, so descriptor and data bytes keep their interleaving. The stimulus issues every end marker with a good, bad or abort code. It drives the receive inputs and the CPU read only at falling edges, with one byte or strobe per cycle. Each scenario reads the buffer fully empty before the next starts, so a fill level and a reader state that do not match never reach the properties.

// File: rtl/dlrx_pkg.sv
package dlrx_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 2;
    localparam int CNT_W  = BYTE_W - CODE_W;

    typedef enum logic [1:0] {
        CODE_CONT  = 2'b00,
        CODE_GOOD  = 2'b01,
        CODE_BAD   = 2'b10,
        CODE_ABORT = 2'b11
    } seg_code_e;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_OPEN = 2'd1,
        W_DROP = 2'd2
    } wr_state_e;

    typedef enum logic {
        R_STAT = 1'b0,
        R_DATA = 1'b1
    } rd_state_e;

    function automatic logic [BYTE_W-1:0] mk_desc(input logic [CODE_W-1:0] code,
                                                  input logic [CNT_W-1:0] cnt);
        return {code, cnt};
    endfunction
endpackage

// File: rtl/dlrx_byte_store.sv
module dlrx_byte_store
    import dlrx_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              we_a,
    input  logic [AW-1:0]     addr_a,
    input  logic [BYTE_W-1:0] dat_a,
    input  logic              we_b,
    input  logic [AW-1:0]     addr_b,
    input  logic [BYTE_W-1:0] dat_b,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdat
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_a) mem[addr_a] <= dat_a;
        if (we_b) mem[addr_b] <= dat_b;
    end

    assign rdat = mem[raddr];
endmodule

// File: rtl/dlrx_seg_writer.sv
module dlrx_seg_writer
    import dlrx_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              end_vld,
    input  logic [CODE_W-1:0] end_code,
    input  logic [AW:0]       rptr,
    output logic [AW:0]       wptr,
    output logic [AW:0]       cptr,
    output logic              dwe,
    output logic [AW-1:0]     daddr,
    output logic [BYTE_W-1:0] ddat,
    output logic              swe,
    output logic [AW-1:0]     saddr,
    output logic [BYTE_W-1:0] sdat,
    output logic              ovf_set
);
    localparam int PW      = AW + 1;
    localparam int DEPTH   = 1 << AW;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    wr_state_e          st_q, st_n;
    logic [PW-1:0]      wptr_q, wptr_n, cptr_q, cptr_n, start_q, start_n;
    logic [CNT_W-1:0]   cnt_q, cnt_n, cnt_inc;
    logic [PW-1:0]      free, wp1, wp2;

    assign free    = PW'(DEPTH) - (wptr_q - rptr);
    assign wp1     = wptr_q + PW'(1);
    assign wp2     = wptr_q + PW'(2);
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign ddat    = byte_in;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= W_IDLE;
            wptr_q  <= '0;
            cptr_q  <= '0;
            start_q <= '0;
            cnt_q   <= '0;
        end else begin
            st_q    <= st_n;
            wptr_q  <= wptr_n;
            cptr_q  <= cptr_n;
            start_q <= start_n;
            cnt_q   <= cnt_n;
        end
    end

    // next state and write controls
    always_comb begin
        st_n    = st_q;
        wptr_n  = wptr_q;
        cptr_n  = cptr_q;
        start_n = start_q;
        cnt_n   = cnt_q;
        dwe     = 1'b0;
        daddr   = wptr_q[AW-1:0];
        swe     = 1'b0;
        saddr   = wptr_q[AW-1:0];
        sdat    = '0;
        ovf_set = 1'b0;
        unique case (st_q)
            W_IDLE: begin
                if (byte_vld) begin
                    if (free >= PW'(2)) begin
                        dwe     = 1'b1;
                        daddr   = wp1[AW-1:0];
                        wptr_n  = wp2;
                        start_n = wptr_q;
                        cnt_n   = CNT_W'(1);
                        if (end_vld) begin
                            swe    = 1'b1;
                            sdat   = mk_desc(end_code, CNT_W'(1));
                            cptr_n = wp2;
                        end else if (free == PW'(2)) begin
                            swe    = 1'b1;
                            sdat   = mk_desc(CODE_CONT, CNT_W'(1));
                            cptr_n = wp2;
                        end else begin
                            st_n = W_OPEN;
                        end
                    end else begin
                        ovf_set = 1'b1;
                        if (free == PW'(1)) begin
                            swe    = 1'b1;
                            sdat   = mk_desc(CODE_ABORT, '0);
                            wptr_n = wp1;
                            cptr_n = wp1;
                        end
                        if (!end_vld) st_n = W_DROP;
                    end
                end else if (end_vld) begin
                    if (free != '0) begin
                        swe    = 1'b1;
                        sdat   = mk_desc(end_code, '0);
                        wptr_n = wp1;
                        cptr_n = wp1;
                    end else begin
                        ovf_set = 1'b1;
                    end
                end
            end
            W_OPEN: begin
                saddr = start_q[AW-1:0];
                if (byte_vld) begin
                    dwe    = 1'b1;
                    wptr_n = wp1;
                    cnt_n  = cnt_inc;
                    if (end_vld) begin
                        swe    = 1'b1;
                        sdat   = mk_desc(end_code, cnt_inc);
                        cptr_n = wp1;
                        st_n   = W_IDLE;
                    end else if (free == PW'(1) || cnt_inc == CNT_W'(CNT_MAX)) begin
                        swe    = 1'b1;
                        sdat   = mk_desc(CODE_CONT, cnt_inc);
                        cptr_n = wp1;
                        st_n   = W_IDLE;
                    end
                end else if (end_vld) begin
                    swe    = 1'b1;
                    sdat   = mk_desc(end_code, cnt_q);
                    cptr_n = wptr_q;
                    st_n   = W_IDLE;
                end
            end
            W_DROP: begin
                if (end_vld) st_n = W_IDLE;
            end
            default: st_n = W_IDLE;
        endcase
    end

    assign wptr = wptr_q;
    assign cptr = cptr_q;
endmodule

// File: rtl/dlrx_seg_reader.sv
module dlrx_seg_reader
    import dlrx_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [AW:0]       cptr,
    input  logic [BYTE_W-1:0] mem_dat,
    output logic [AW:0]       rptr,
    output logic              avail,
    output logic              next_stat,
    output logic [BYTE_W-1:0] rd_data
);
    rd_state_e        st_q, st_n;
    logic [AW:0]      rptr_q, rptr_n;
    logic [CNT_W-1:0] rem_q, rem_n;
    logic             pop;

    assign avail = (cptr != rptr_q);
    assign pop   = rd_req & avail;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= R_STAT;
            rptr_q <= '0;
            rem_q  <= '0;
        end else begin
            st_q   <= st_n;
            rptr_q <= rptr_n;
            rem_q  <= rem_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st_q;
        rem_n  = rem_q;
        rptr_n = rptr_q + {{AW{1'b0}}, pop};
        unique case (st_q)
            R_STAT: begin
                if (pop) begin
                    rem_n = mem_dat[CNT_W-1:0];
                    if (mem_dat[CNT_W-1:0] != '0) st_n = R_DATA;
                end
            end
            R_DATA: begin
                if (pop) begin
                    rem_n = rem_q - CNT_W'(1);
                    if (rem_q == CNT_W'(1)) st_n = R_STAT;
                end
            end
            default: st_n = R_STAT;
        endcase
    end

    // outputs
    always_comb begin
        rd_data   = avail ? mem_dat : '0;
        next_stat = (st_q == R_STAT);
        rptr      = rptr_q;
    end
endmodule

// File: rtl/dlrx_nf_flag.sv
module dlrx_nf_flag #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW:0]   wptr,
    input  logic [AW:0]   rptr,
    input  logic [AW-1:0] thresh,
    input  logic          irq_clr,
    output logic          near_full,
    output logic          irq
);
    logic [AW:0] fill;
    logic        nf_q, irq_q;

    assign fill      = wptr - rptr;
    assign near_full = (fill > {1'b0, thresh});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nf_q  <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            nf_q  <= near_full;
            irq_q <= (near_full & ~nf_q) | (irq_q & ~irq_clr);
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/dlrx_msg_fifo.sv
module dlrx_msg_fifo
    import dlrx_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_byte_vld,
    input  logic [7:0]  rx_byte,
    input  logic        rx_end_vld,
    input  logic [1:0]  rx_end_code,
    input  logic [AW-1:0] nf_thresh,
    input  logic        cpu_rd,
    output logic [7:0]  cpu_rd_data,
    output logic        cpu_rd_avail,
    output logic        cpu_next_is_stat,
    output logic        near_full,
    output logic        near_full_irq,
    input  logic        irq_clr,
    output logic        overflow,
    input  logic        ovf_clr
);
    logic [AW:0]       wptr, cptr, rptr;
    logic              dwe, swe, ovf_set, ovf_q;
    logic [AW-1:0]     daddr, saddr;
    logic [BYTE_W-1:0] ddat, sdat, mem_dat;

    dlrx_seg_writer #(.AW(AW)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .byte_vld(rx_byte_vld), .byte_in(rx_byte),
        .end_vld(rx_end_vld), .end_code(rx_end_code),
        .rptr(rptr), .wptr(wptr), .cptr(cptr),
        .dwe(dwe), .daddr(daddr), .ddat(ddat),
        .swe(swe), .saddr(saddr), .sdat(sdat),
        .ovf_set(ovf_set)
    );

    dlrx_byte_store #(.AW(AW)) u_mem (
        .clk(clk),
        .we_a(dwe), .addr_a(daddr), .dat_a(ddat),
        .we_b(swe), .addr_b(saddr), .dat_b(sdat),
        .raddr(rptr[AW-1:0]), .rdat(mem_dat)
    );

    dlrx_seg_reader #(.AW(AW)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .rd_req(cpu_rd), .cptr(cptr), .mem_dat(mem_dat),
        .rptr(rptr), .avail(cpu_rd_avail),
        .next_stat(cpu_next_is_stat), .rd_data(cpu_rd_data)
    );

    dlrx_nf_flag #(.AW(AW)) u_nf (
        .clk(clk), .rst_n(rst_n),
        .wptr(wptr), .rptr(rptr), .thresh(nf_thresh),
        .irq_clr(irq_clr), .near_full(near_full), .irq(near_full_irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
    end

    assign overflow = ovf_q;
endmodule

// File: rtl/dlrx_msg_fifo_chk.sv
module dlrx_msg_fifo_chk #(
    parameter int AW = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic [AW:0] wptr,
    input logic [AW:0] cptr,
    input logic [AW:0] rptr,
    input logic        cpu_rd,
    input logic        cpu_rd_avail,
    input logic [7:0]  cpu_rd_data,
    input logic        cpu_next_is_stat,
    input logic        near_full,
    input logic        near_full_irq,
    input logic        irq_clr,
    input logic        overflow,
    input logic        ovf_clr
);
    localparam int DEPTH = 1 << AW;

    assert_fill_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr - rptr) <= (AW+1)'(DEPTH));

    assert_commit_behind_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cptr - rptr) <= (wptr - rptr));

    assert_empty_read_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_rd_avail) |=> $stable(rptr));

    assert_zero_count_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_rd_avail && cpu_next_is_stat && cpu_rd_data[5:0] == 6'd0)
        |=> cpu_next_is_stat);

    assert_data_follows_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_rd_avail && cpu_next_is_stat && cpu_rd_data[5:0] != 6'd0)
        |=> !cpu_next_is_stat);

    assert_irq_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(near_full) |=> near_full_irq);

    assert_irq_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (near_full_irq && !irq_clr) |=> near_full_irq);

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !ovf_clr) |=> overflow);
endmodule

bind dlrx_msg_fifo dlrx_msg_fifo_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .wptr(wptr), .cptr(cptr), .rptr(rptr),
    .cpu_rd(cpu_rd), .cpu_rd_avail(cpu_rd_avail), .cpu_rd_data(cpu_rd_data),
    .cpu_next_is_stat(cpu_next_is_stat),
    .near_full(near_full), .near_full_irq(near_full_irq), .irq_clr(irq_clr),
    .overflow(overflow), .ovf_clr(ovf_clr)
);

// File: tb/tb_dlrx_msg_fifo.sv
module tb_dlrx_msg_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_byte_vld = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_end_vld = 1'b0;
    logic [1:0] rx_end_code = '0;
    logic [5:0] nf_thresh = 6'd63;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_rd_data;
    logic       cpu_rd_avail, cpu_next_is_stat, near_full, near_full_irq, overflow;
    logic       irq_clr = 1'b0;
    logic       ovf_clr = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    dlrx_msg_fifo dut (
        .clk(clk), .rst_n(rst_n),
        .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte),
        .rx_end_vld(rx_end_vld), .rx_end_code(rx_end_code),
        .nf_thresh(nf_thresh), .cpu_rd(cpu_rd), .cpu_rd_data(cpu_rd_data),
        .cpu_rd_avail(cpu_rd_avail), .cpu_next_is_stat(cpu_next_is_stat),
        .near_full(near_full), .near_full_irq(near_full_irq), .irq_clr(irq_clr),
        .overflow(overflow), .ovf_clr(ovf_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic push(input logic [7:0] b, input bit last, input logic [1:0] code);
        rx_byte_vld = 1'b1; rx_byte = b; rx_end_vld = last; rx_end_code = code;
        @(negedge clk);
        rx_byte_vld = 1'b0; rx_end_vld = 1'b0;
    endtask

    task automatic end_only(input logic [1:0] code);
        rx_end_vld = 1'b1; rx_end_code = code;
        @(negedge clk);
        rx_end_vld = 1'b0;
    endtask

    task automatic pop_chk(input logic [7:0] exp, input bit exp_stat, input string req);
        chk(cpu_rd_avail == 1'b1, req, cpu_rd_avail, 1);
        chk(cpu_next_is_stat == exp_stat, {req, " flag"}, cpu_next_is_stat, exp_stat);
        chk(cpu_rd_data == exp, req, cpu_rd_data, exp);
        cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk(cpu_rd_avail == 0, "R10 avail", cpu_rd_avail, 0);
        chk(cpu_rd_data == 0, "R10 data", cpu_rd_data, 0);
        chk(cpu_next_is_stat == 1, "R10 flag", cpu_next_is_stat, 1);
        chk(near_full == 0 && near_full_irq == 0, "R10 nf", {near_full, near_full_irq}, 0);
        chk(overflow == 0, "R10 ovf", overflow, 0);
    endtask

    task automatic t_simple();
        push(8'hA1, 0, 2'b01);
        push(8'hA2, 0, 2'b01);
        chk(cpu_rd_avail == 0, "R3 open hidden", cpu_rd_avail, 0);
        push(8'hA3, 1, 2'b01);
        pop_chk(8'h43, 1, "R2 good desc");
        pop_chk(8'hA1, 0, "R5 data1");
        pop_chk(8'hA2, 0, "R5 data2");
        pop_chk(8'hA3, 0, "R5 data3");
        chk(cpu_next_is_stat == 1, "R5 back to desc", cpu_next_is_stat, 1);
        chk(cpu_rd_avail == 0, "R2 drained", cpu_rd_avail, 0);
    endtask

    task automatic t_codes();
        push(8'h5C, 1, 2'b10);
        end_only(2'b11);
        pop_chk(8'h81, 1, "R2 bad desc");
        pop_chk(8'h5C, 0, "R2 bad data");
        pop_chk(8'hC0, 1, "R4 count0 desc");
        chk(cpu_next_is_stat == 1, "R5 count0 stays desc", cpu_next_is_stat, 1);
    endtask

    task automatic t_empty_read();
        cpu_rd = 1'b1;
        chk(cpu_rd_data == 0, "R6 empty data", cpu_rd_data, 0);
        @(negedge clk);
        cpu_rd = 1'b0;
        push(8'h11, 0, 2'b01);
        push(8'h22, 1, 2'b01);
        pop_chk(8'h42, 1, "R6 no move desc");
        pop_chk(8'h11, 0, "R6 data1");
        pop_chk(8'h22, 0, "R6 data2");
    endtask

    task automatic t_near_full();
        nf_thresh = 6'd4;
        push(8'h01, 0, 2'b01);
        push(8'h02, 0, 2'b01);
        push(8'h03, 0, 2'b01);
        chk(near_full == 0, "R7 fill4 eq thr", near_full, 0);
        push(8'h04, 0, 2'b01);
        chk(near_full == 1, "R7 fill5 above", near_full, 1);
        chk(near_full_irq == 0, "R8 irq not yet", near_full_irq, 0);
        @(negedge clk);
        chk(near_full_irq == 1, "R8 irq set", near_full_irq, 1);
        @(negedge clk);
        chk(near_full_irq == 1, "R8 irq held", near_full_irq, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(near_full_irq == 0, "R8 irq cleared", near_full_irq, 0);
        @(negedge clk);
        chk(near_full_irq == 0 && near_full == 1, "R8 no reset while high", near_full_irq, 0);
        end_only(2'b01);
        pop_chk(8'h44, 1, "R7 desc");
        for (int i = 1; i <= 4; i++) pop_chk(8'(i), 0, "R7 data");
        chk(near_full == 0, "R7 drained", near_full, 0);
        nf_thresh = 6'd0;
        end_only(2'b10);
        chk(near_full == 1, "R7 thr0 one slot", near_full, 1);
        pop_chk(8'h80, 1, "R7 thr0 desc");
        chk(near_full == 0, "R7 thr0 empty", near_full, 0);
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        nf_thresh = 6'd63;
    endtask

    task automatic t_force_cont();
        for (int i = 1; i <= 63; i++) begin
            push(8'(i + 8'h20), 0, 2'b01);
            if (i == 62) chk(cpu_rd_avail == 0, "R3 long open", cpu_rd_avail, 0);
        end
        chk(cpu_rd_avail == 1, "R4 forced close", cpu_rd_avail, 1);
        chk(near_full == 1, "R1 full above 63", near_full, 1);
        push(8'hEE, 0, 2'b01);
        push(8'hEF, 0, 2'b01);
        push(8'hF0, 1, 2'b01);
        chk(overflow == 1, "R9 full overflow", overflow, 1);
        pop_chk(8'h3F, 1, "R4 cont desc");
        for (int i = 1; i <= 63; i++) pop_chk(8'(i + 8'h20), 0, "R1 data");
        chk(cpu_rd_avail == 0, "R9 dropped bytes absent", cpu_rd_avail, 0);
        chk(cpu_next_is_stat == 1, "R5 after long", cpu_next_is_stat, 1);
        chk(overflow == 1, "R9 sticky", overflow, 1);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk(overflow == 0, "R9 cleared", overflow, 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
    endtask

    task automatic t_abort_marker();
        for (int i = 1; i <= 62; i++) push(8'(i + 8'h80), i == 62, 2'b01);
        chk(overflow == 0, "R9 fits exactly", overflow, 0);
        push(8'h99, 0, 2'b01);
        push(8'h9A, 1, 2'b01);
        chk(overflow == 1, "R9 one free overflow", overflow, 1);
        pop_chk(8'h7E, 1, "R9 good desc");
        for (int i = 1; i <= 62; i++) pop_chk(8'(i + 8'h80), 0, "R9 data");
        pop_chk(8'hC0, 1, "R9 abort marker");
        chk(cpu_rd_avail == 0, "R9 nothing after marker", cpu_rd_avail, 0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_simple();
        t_codes();
        t_empty_read();
        t_near_full();
        t_force_cont();
        t_abort_marker();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule